// File: doc/BRIEF.md
# Registered Bus Transceiver Slice

This block joins a narrow local data path to a shared bus on which released lines read as logic low and the resolved value of each line is the OR of all active drivers. A transmit register is loaded from one of two local input groups, or from both combined, and otherwise keeps its value. A drive flag, also registered, decides whether the transmit register reaches the bus or whether the outputs fall back to a passive low that does not drive. Since a driven zero and a released line both read as zero on this bus, several slices can share the lines without contention.

On the receive side, the resolved bus value is masked by a receive enable and then captured in a receive register. Every register in the slice is clocked by the OR of two clock inputs, so an edge on either input, or on both, updates the slice. A synchronous active-high reset empties both registers and clears the drive flag, so the slice starts with its outputs released.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, the transmit register, the receive register and the drive flag clear. After that edge, `bus_out`, `rx_q` and `drv_on` read 0.
- R2: When both bits of `tx_ld` are 0, the transmit register keeps its value, whatever `a_in` and `b_in` are.
- R3: `drv_on` at each edge takes the OR of the `drv_en` bits. It goes low only when every bit of `drv_en` is 0. A change on `drv_en` reaches `bus_out` one edge later and never combinationally.
- R4: When `drv_on` is 0, `bus_out` reads all zeros. A released slice then cannot change the resolved bus value.
- R5: At each edge the receive register captures `bus_in` ANDed with `rx_en`. When `rx_en` is 0 it captures zeros.
- R6: The load source depends on `tx_ld`. With `tx_ld` = 01 it loads `a_in`, with 10 it loads `b_in`, and with 11 it loads `a_in | b_in`.
- R7: When two slices on one bus both drive, each bus line resolves to the OR of their `bus_out` values. A receiving slice captures that OR value one edge after the bus settles.
- R8: A rising edge on `clk_a` alone or on `clk_b` alone updates all registers. The registers are clocked by `clk_a | clk_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First clock input, ORed with `clk_b` |
| clk_b | input | 1 | Second clock input, ORed with `clk_a` |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | First local data group |
| b_in | input | W | Second local data group |
| tx_ld | input | 2 | Transmit load enables. Bit 0 selects `a_in` and bit 1 selects `b_in` |
| drv_en | input | NEN | Drive requests. Drive is off only when every bit is 0 |
| rx_en | input | 1 | Receive gate applied to `bus_in` |
| bus_in | input | W | Resolved value of the shared bus |
| bus_out | output | W | Transmit value when driving, zeros when released |
| rx_q | output | W | Receive register |
| drv_on | output | 1 | Registered drive flag |

## Verification
The bench changes inputs on falling edges and reads outputs on the next falling edge. Each result is therefore sampled half a period after the rising edge that is due to produce it. A transmit load or a drive-enable change must appear on `bus_out` and on the bus one edge after it is applied. To show that nothing acts combinationally, the bench also reads the bus right after changing `drv_en`, while the old value must still hold. Received data is due one edge after the bus settles, which is two edges after the transmit inputs change. Each receive check waits exactly that number of edges.

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W   = 3,
  parameter int NEN = 2
) (
  input  logic           clk_a,
  input  logic           clk_b,
  input  logic           rst,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  input  logic [1:0]     tx_ld,
  input  logic [NEN-1:0] drv_en,
  input  logic           rx_en,
  input  logic [W-1:0]   bus_in,
  output logic [W-1:0]   bus_out,
  output logic [W-1:0]   rx_q,
  output logic           drv_on
);

  logic         clk;
  logic [W-1:0] tx_q;
  logic [W-1:0] tx_next;
  logic [W-1:0] rx_r;
  logic         drv_q;

  assign clk     = clk_a | clk_b;
  assign tx_next = ({W{tx_ld[0]}} & a_in) | ({W{tx_ld[1]}} & b_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= '0;
      rx_r  <= '0;
      drv_q <= 1'b0;
    end else begin
      if (|tx_ld) tx_q <= tx_next;
      drv_q <= |drv_en;
      rx_r  <= bus_in & {W{rx_en}};
    end
  end

  assign bus_out = tx_q & {W{drv_q}};
  assign rx_q    = rx_r;
  assign drv_on  = drv_q;

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int W   = 3,
  parameter int NEN = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   a_in,
  input logic [W-1:0]   b_in,
  input logic [1:0]     tx_ld,
  input logic [NEN-1:0] drv_en,
  input logic           rx_en,
  input logic [W-1:0]   bus_in,
  input logic [W-1:0]   bus_out,
  input logic [W-1:0]   rx_q,
  input logic [W-1:0]   tx_q,
  input logic           drv_on
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (rx_q == '0 && bus_out == '0 && !drv_on && tx_q == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_ld == 2'b00) |=> $stable(tx_q));

  a_r3_drive_flag: assert property (@(posedge clk) disable iff (rst)
    (drv_en == '0) |=> !drv_on);

  a_r3_drive_on: assert property (@(posedge clk) disable iff (rst)
    (drv_en != '0) |=> drv_on);

  a_r4_released_low: assert property (@(posedge clk) disable iff (rst)
    (drv_en == '0) |=> (bus_out == '0));

  a_r5_rx_gated: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (rx_q == '0));

  a_r5_rx_capture: assert property (@(posedge clk) disable iff (rst)
    rx_en |=> (rx_q == $past(bus_in)));

  a_r6_both_loads: assert property (@(posedge clk) disable iff (rst)
    (tx_ld == 2'b11) |=> (tx_q == $past(a_in | b_in)));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W), .NEN(NEN)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .tx_ld(tx_ld),
  .drv_en(drv_en), .rx_en(rx_en), .bus_in(bus_in), .bus_out(bus_out),
  .rx_q(rx_q), .tx_q(tx_q), .drv_on(drv_on)
);

// File: tb/regbus_xcvr_tb_top.sv
module regbus_xcvr_tb_top;
  localparam int W = 3;

  logic ck = 1'b0;
  logic sel_a = 1'b1;
  logic sel_b = 1'b0;
  logic clk_a, clk_b;
  logic rst = 1'b1;
  always #2 ck = ~ck;
  assign clk_a = ck & sel_a;
  assign clk_b = ck & sel_b;

  logic [W-1:0] a0 = '0, b0 = '0, a1 = '0, b1 = '0;
  logic [1:0]   ld0 = '0, ld1 = '0, de0 = '0, de1 = '0;
  logic         rxe0 = 1'b0, rxe1 = 1'b0;
  logic [W-1:0] out0, out1, q0, q1, bus;
  logic         on0, on1;

  assign bus = out0 | out1;

  regbus_xcvr #(.W(W), .NEN(2)) dut_i (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .a_in(a0), .b_in(b0),
    .tx_ld(ld0), .drv_en(de0), .rx_en(rxe0), .bus_in(bus),
    .bus_out(out0), .rx_q(q0), .drv_on(on0));

  regbus_xcvr #(.W(W), .NEN(2)) nb_i (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .a_in(a1), .b_in(b1),
    .tx_ld(ld1), .drv_en(de1), .rx_en(rxe1), .bus_in(bus),
    .bus_out(out1), .rx_q(q1), .drv_on(on1));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge ck) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge ck);
      @(negedge ck);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; step(2);
    chk("R1 bus_out dut", out0, 0);
    chk("R1 bus_out nb", out1, 0);
    chk("R1 rx_q dut", q0, 0);
    chk("R1 drv_on dut", {2'b0, on0}, 0);
    rst = 1'b0;
  endtask

  task automatic t_load_hold;
    a0 = 3'd5; ld0 = 2'b01; de0 = 2'b01; step();
    chk("R6 load A", out0, 3'd5);
    chk("R3 drive one edge", bus, 3'd5);
    a0 = 3'd2; b0 = 3'd7; ld0 = 2'b00; step(2);
    chk("R2 hold", out0, 3'd5);
  endtask

  task automatic t_release;
    de0 = 2'b00;
    #0.5;
    chk("R3 no combinational release", bus, 3'd5);
    step();
    chk("R4 released reads 0", out0, 3'd0);
    chk("R3 drv_on low", {2'b0, on0}, 0);
    de0 = 2'b10; step();
    chk("R3 second enable alone drives", out0, 3'd5);
    de0 = 2'b00; step();
    a1 = 3'd3; ld1 = 2'b01; de1 = 2'b01; step();
    chk("R4 released slice leaves bus", bus, 3'd3);
  endtask

  task automatic t_rx_gate;
    rxe0 = 1'b1; step();
    chk("R5 rx captures bus", q0, 3'd3);
    rxe0 = 1'b0; step();
    chk("R5 rx gated to 0", q0, 3'd0);
  endtask

  task automatic t_select;
    a0 = 3'd4; b0 = 3'd1; ld0 = 2'b11; de0 = 2'b01; de1 = 2'b00; step();
    chk("R6 load A|B", out0, 3'd5);
    a0 = 3'd7; b0 = 3'd6; ld0 = 2'b10; step();
    chk("R6 load B only", out0, 3'd6);
    ld0 = 2'b00;
  endtask

  task automatic t_wired_or;
    a0 = 3'd4; ld0 = 2'b01; de0 = 2'b01;
    a1 = 3'd2; ld1 = 2'b01; de1 = 2'b11; rxe1 = 1'b1; step();
    chk("R7 bus is OR", bus, 3'd6);
    step();
    chk("R7 receiver gets OR", q1, 3'd6);
    ld0 = 2'b00; ld1 = 2'b00;
  endtask

  task automatic t_clocks;
    sel_a = 1'b0; sel_b = 1'b1;
    a0 = 3'd1; ld0 = 2'b01; step();
    chk("R8 clk_b alone updates", out0, 3'd1);
    sel_a = 1'b1; sel_b = 1'b1;
    a0 = 3'd3; step();
    chk("R8 both clocks update", out0, 3'd3);
    sel_a = 1'b1; sel_b = 1'b0;
    a0 = 3'd2; step();
    chk("R8 clk_a alone updates", out0, 3'd2);
  endtask

  initial begin
    @(negedge ck);
    t_reset();
    t_load_hold();
    t_release();
    t_rx_gate();
    t_select();
    t_wired_or();
    t_clocks();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule